// File: doc/BRIEF.md
# Indexed Control Register Bank

This block is an 8-bit bus slave that puts four configuration registers behind a single data offset. Software writes a 2-bit index at one offset and then reads or writes the selected register at the next offset. The four indexed registers are these: a system control register, a serial clock control register, a write-only port output register and a port direction register.

The system control register drives a decoded crystal divider ratio, three serial channel enables, a switch-on disable bit and an interrupt source select. The serial clock control register drives four continuous-clock enables. The port output register drives an 8-bit general-purpose port. A write to it is masked by the direction register, so only pins set as outputs take the written value.

A status register samples a frame-received flag and the slave data line. It raises a registered interrupt whenever either sampled bit is high. A further offset returns the port input pins directly, for polling.

Top module: `icrb_top`

## Requirements
- R1: A write to offset 0 stores bits 1:0 of the write data as the index. A read of offset 0 returns the index in bits 1:0, with bits 7:2 zero.
- R2: Offset 1 accesses the indexed register: index 0 is system control, index 1 is serial clock control and index 3 is port direction. Each of these reads back the full byte last written. `port_oe` always equals the direction register.
- R3: A write to offset 1 with index 2 sets `port_out` to (write data AND direction register) on the clock edge of the write. A later change to the direction register leaves `port_out` unchanged.
- R4: A read of offset 1 with index 2 returns 0x00.
- R5: `div_ratio` follows system control bits 1:0: values 0 and 1 give 3, value 2 gives 2, and value 3 gives 1.
- R6: `chan_en[0]`, `chan_en[1]` and `chan_en[2]` equal system control bits 2, 3 and 4 (channels 3, 4 and 6). `switch_on_dis` equals bit 5 and `irq_src_sel` equals bit 6.
- R7: `cont_clk_en[3:0]` equals serial clock control bits 3:0 (channels 1 to 4).
- R8: A read of offset 5 returns the status register. Bit 0 holds `frame_flag` and bit 5 holds `slave_data`, each as sampled at the previous clock edge. All other bits read zero.
- R9: `irq` is high exactly when status bit 0 or status bit 5 was set in the previous cycle, so it follows an input change by two clock edges.
- R10: A read of offset 6 returns `port_in` in the same cycle.
- R11: After reset the index, the three stored registers, `port_out`, the status register and `irq` are all zero.
- R12: Writes to offsets other than 0 and 1 change no state. Reads of offsets 2, 3, 4 and 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the offset |
| port_in | input | 8 | Port input pins |
| frame_flag | input | 1 | Frame-received flag level |
| slave_data | input | 1 | Slave data line level |
| port_out | output | 8 | Port output value |
| port_oe | output | 8 | Port output enables (direction) |
| div_ratio | output | 2 | Decoded crystal divider ratio (1, 2 or 3) |
| chan_en | output | 3 | Serial channel 3, 4, 6 enables |
| cont_clk_en | output | 4 | Continuous clock enables, channels 1 to 4 |
| switch_on_dis | output | 1 | Switch-on disable |
| irq_src_sel | output | 1 | Interrupt source select |
| irq | output | 1 | Registered interrupt |

## Verification
Register writes take effect on the clock edge that samples the write. The bench therefore drives each access at a falling edge and compares the configuration outputs at the following falling edge. Read data is combinational, so reads are sampled 1 ns after the address is applied, before the next rising edge. The status register lags its inputs by one edge and the interrupt by two. The bench changes the inputs at a falling edge, then checks the interrupt at the next falling edge for its old value and one edge later for its new value.

// File: rtl/icrb_pkg.sv
package icrb_pkg;
   // Fixed positions inside the indexed bank; software depends on them.
   localparam int CTRL0_IDX = 0;
   localparam int CTRL1_IDX = 1;
   localparam int WO_IDX    = 2;
   localparam int DDR_IDX   = 3;

   // Bit fields of system control
   localparam int C0_DIV_LO  = 0;
   localparam int C0_CH3     = 2;
   localparam int C0_CH4     = 3;
   localparam int C0_CH6     = 4;
   localparam int C0_SWOFF   = 5;
   localparam int C0_SRCSEL  = 6;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_INDEX,
      SEL_DATA,
      SEL_STATUS,
      SEL_PORTIN
   } icrb_sel_e;
endpackage

// File: rtl/icrb_decode.sv
module icrb_decode #(
   parameter int ADDR_W     = 3,
   parameter int OFF_INDEX  = 0,
   parameter int OFF_DATA   = 1,
   parameter int OFF_STATUS = 5,
   parameter int OFF_PORTIN = 6
) (
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output icrb_pkg::icrb_sel_e sel,
   output logic              wr_index,
   output logic              wr_data
);
   import icrb_pkg::*;

   localparam logic [ADDR_W-1:0] A_INDEX  = ADDR_W'(OFF_INDEX);
   localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFF_DATA);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
   localparam logic [ADDR_W-1:0] A_PORTIN = ADDR_W'(OFF_PORTIN);

   always_comb begin
      sel = SEL_NONE;
      if (bus_addr == A_INDEX)       sel = SEL_INDEX;
      else if (bus_addr == A_DATA)   sel = SEL_DATA;
      else if (bus_addr == A_STATUS) sel = SEL_STATUS;
      else if (bus_addr == A_PORTIN) sel = SEL_PORTIN;
   end

   assign wr_index = bus_sel && bus_wr && (sel == SEL_INDEX);
   assign wr_data  = bus_sel && bus_wr && (sel == SEL_DATA);
endmodule

// File: rtl/icrb_regs.sv
module icrb_regs #(
   parameter int DATA_W = 8,
   parameter int PORT_W = 8,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_index,
   input  logic              wr_data,
   input  logic [DATA_W-1:0] wdata,
   output logic [IDX_W-1:0]  idx_q,
   output logic [DATA_W-1:0] ind_rdata,
   output logic [DATA_W-1:0] ctrl0,
   output logic [DATA_W-1:0] ctrl1,
   output logic [PORT_W-1:0] ddr,
   output logic [PORT_W-1:0] pout_q
);
   import icrb_pkg::*;

   localparam int NREG = 1 << IDX_W;

   logic [DATA_W-1:0] reg_q [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (wr_index) begin
         idx_q <= wdata[IDX_W-1:0];
      end
   end

   // Storage for every index except the write-only slot.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) reg_q[i] <= '0;
      end else begin
         for (int i = 0; i < NREG; i++) begin
            if (wr_data && (idx_q == IDX_W'(i)) && (i != WO_IDX))
               reg_q[i] <= wdata;
         end
      end
   end

   // Port output is captured through the direction mask at write time.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pout_q <= '0;
      end else if (wr_data && (idx_q == IDX_W'(WO_IDX))) begin
         pout_q <= wdata[PORT_W-1:0] & reg_q[DDR_IDX][PORT_W-1:0];
      end
   end

   // Read view: the write-only slot always reads as zero.
   logic [DATA_W-1:0] view [NREG];
   for (genvar g = 0; g < NREG; g++) begin : g_view
      if (g == WO_IDX) begin : g_wo
         assign view[g] = '0;
      end else begin : g_rw
         assign view[g] = reg_q[g];
      end
   end

   assign ind_rdata = view[idx_q];
   assign ctrl0     = reg_q[CTRL0_IDX];
   assign ctrl1     = reg_q[CTRL1_IDX];
   assign ddr       = reg_q[DDR_IDX][PORT_W-1:0];
endmodule

// File: rtl/icrb_status.sv
module icrb_status #(
   parameter int DATA_W        = 8,
   parameter int FLAG_BIT      = 0,
   parameter int SLAVE_BIT     = 5,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_flag,
   input  logic              slave_data,
   output logic [DATA_W-1:0] stat_q,
   output logic              irq
);
   logic [DATA_W-1:0] stat_d;

   always_comb begin
      stat_d            = '0;
      stat_d[FLAG_BIT]  = frame_flag;
      stat_d[SLAVE_BIT] = slave_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end

   logic irq_d;
   assign irq_d = stat_q[FLAG_BIT] | stat_q[SLAVE_BIT];

   if (IRQ_REGISTERED) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_d;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_d;
   end
endmodule

// File: rtl/icrb_top.sv
module icrb_top #(
   parameter int DATA_W        = 8,
   parameter int PORT_W        = 8,
   parameter int ADDR_W        = 3,
   parameter int IDX_W         = 2,
   parameter int OFF_INDEX     = 0,
   parameter int OFF_DATA      = 1,
   parameter int OFF_STATUS    = 5,
   parameter int OFF_PORTIN    = 6,
   parameter int FLAG_BIT      = 0,
   parameter int SLAVE_BIT     = 5,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [PORT_W-1:0] port_in,
   input  logic              frame_flag,
   input  logic              slave_data,
   output logic [PORT_W-1:0] port_out,
   output logic [PORT_W-1:0] port_oe,
   output logic [1:0]        div_ratio,
   output logic [2:0]        chan_en,
   output logic [3:0]        cont_clk_en,
   output logic              switch_on_dis,
   output logic              irq_src_sel,
   output logic              irq
);
   import icrb_pkg::*;

   if (DATA_W < 7) begin : g_bad_data_w
      $error("icrb_top: DATA_W must hold the 7 control bits");
   end
   if (PORT_W > DATA_W) begin : g_bad_port_w
      $error("icrb_top: PORT_W must not exceed DATA_W");
   end
   if (IDX_W < 2) begin : g_bad_idx_w
      $error("icrb_top: IDX_W must reach four registers");
   end
   if ((FLAG_BIT >= DATA_W) || (SLAVE_BIT >= DATA_W) || (FLAG_BIT == SLAVE_BIT)) begin : g_bad_stat
      $error("icrb_top: status bit positions invalid");
   end
   if ((1 << ADDR_W) <= OFF_PORTIN) begin : g_bad_addr
      $error("icrb_top: ADDR_W too narrow for offsets");
   end

   icrb_sel_e         sel;
   logic              wr_index, wr_data;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] ind_rdata, ctrl0, ctrl1, stat_q;

   icrb_decode #(
      .ADDR_W(ADDR_W), .OFF_INDEX(OFF_INDEX), .OFF_DATA(OFF_DATA),
      .OFF_STATUS(OFF_STATUS), .OFF_PORTIN(OFF_PORTIN)
   ) u_decode (
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .sel(sel), .wr_index(wr_index), .wr_data(wr_data)
   );

   icrb_regs #(.DATA_W(DATA_W), .PORT_W(PORT_W), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_index(wr_index), .wr_data(wr_data),
      .wdata(bus_wdata), .idx_q(idx_q), .ind_rdata(ind_rdata),
      .ctrl0(ctrl0), .ctrl1(ctrl1), .ddr(port_oe), .pout_q(port_out)
   );

   icrb_status #(
      .DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT), .SLAVE_BIT(SLAVE_BIT),
      .IRQ_REGISTERED(IRQ_REGISTERED)
   ) u_status (
      .clk(clk), .rst_n(rst_n), .frame_flag(frame_flag),
      .slave_data(slave_data), .stat_q(stat_q), .irq(irq)
   );

   // Crystal divider decode
   always_comb begin
      case (ctrl0[C0_DIV_LO +: 2])
         2'd2:    div_ratio = 2'd2;
         2'd3:    div_ratio = 2'd1;
         default: div_ratio = 2'd3;
      endcase
   end

   assign chan_en       = {ctrl0[C0_CH6], ctrl0[C0_CH4], ctrl0[C0_CH3]};
   assign switch_on_dis = ctrl0[C0_SWOFF];
   assign irq_src_sel   = ctrl0[C0_SRCSEL];
   assign cont_clk_en   = ctrl1[3:0];

   logic unused_bits;
   assign unused_bits = ^{ctrl0[DATA_W-1:7], ctrl1[DATA_W-1:4]};

   always_comb begin
      bus_rdata = '0;
      case (sel)
         SEL_INDEX:  bus_rdata = DATA_W'(idx_q);
         SEL_DATA:   bus_rdata = ind_rdata;
         SEL_STATUS: bus_rdata = stat_q;
         SEL_PORTIN: bus_rdata = DATA_W'(port_in);
         default:    bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/icrb_checker.sv
module icrb_checker #(
   parameter int DATA_W        = 8,
   parameter int PORT_W        = 8,
   parameter int ADDR_W        = 3,
   parameter int IDX_W         = 2,
   parameter int OFF_INDEX     = 0,
   parameter int OFF_DATA      = 1,
   parameter int FLAG_BIT      = 0,
   parameter int SLAVE_BIT     = 5,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [PORT_W-1:0] port_out,
   input logic [PORT_W-1:0] port_oe,
   input logic [2:0]        chan_en,
   input logic [IDX_W-1:0]  idx_q,
   input logic [DATA_W-1:0] stat_q,
   input logic              irq
);
   logic wr_idx, wr_dat;
   assign wr_idx = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_INDEX));
   assign wr_dat = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_DATA));

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assert_index_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_idx |=> (idx_q == $past(bus_wdata[IDX_W-1:0])));

   assert_port_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_dat && idx_q == IDX_W'(2)) |=> (port_out == ($past(bus_wdata[PORT_W-1:0]) & port_oe)));

   assert_port_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_dat && idx_q == IDX_W'(2)) |=> $stable(port_out));

   assert_chan_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_dat && idx_q == IDX_W'(0)) |=> (chan_en == $past(bus_wdata[4:2])));

   if (IRQ_REGISTERED) begin : g_irq_chk
      assert_irq_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok |-> (irq == $past(stat_q[FLAG_BIT] | stat_q[SLAVE_BIT])));
   end
endmodule

bind icrb_top icrb_checker #(
   .DATA_W(DATA_W), .PORT_W(PORT_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
   .OFF_INDEX(OFF_INDEX), .OFF_DATA(OFF_DATA), .FLAG_BIT(FLAG_BIT),
   .SLAVE_BIT(SLAVE_BIT), .IRQ_REGISTERED(IRQ_REGISTERED)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .port_out(port_out),
   .port_oe(port_oe), .chan_en(chan_en), .idx_q(idx_q), .stat_q(stat_q),
   .irq(irq)
);

// File: tb/icrb_top_bench.sv
`timescale 1ns/1ps
module icrb_top_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic [7:0] port_in = '0;
   logic       frame_flag = 1'b0, slave_data = 1'b0;
   logic [7:0] port_out, port_oe;
   logic [1:0] div_ratio;
   logic [2:0] chan_en;
   logic [3:0] cont_clk_en;
   logic       switch_on_dis, irq_src_sel, irq;

   int checks = 0;
   int errors = 0;

   // Bench model of the register state
   logic [1:0] m_idx = '0;
   logic [7:0] m_c0 = '0, m_c1 = '0, m_ddr = '0, m_pout = '0, m_stat = '0;

   always #2 clk = ~clk;

   icrb_top u_icrb_top (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .port_in(port_in), .frame_flag(frame_flag), .slave_data(slave_data),
      .port_out(port_out), .port_oe(port_oe), .div_ratio(div_ratio),
      .chan_en(chan_en), .cont_clk_en(cont_clk_en),
      .switch_on_dis(switch_on_dis), .irq_src_sel(irq_src_sel), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_div(input logic [7:0] c0);
      case (c0[1:0])
         2'd2:    return 2'd2;
         2'd3:    return 2'd1;
         default: return 2'd3;
      endcase
   endfunction

   function automatic logic [7:0] exp_rd(input logic [2:0] a);
      case (a)
         3'd0: return {6'b0, m_idx};
         3'd1: case (m_idx)
                  2'd0: return m_c0;
                  2'd1: return m_c1;
                  2'd2: return 8'h00;
                  default: return m_ddr;
               endcase
         3'd5: return m_stat;
         3'd6: return port_in;
         default: return 8'h00;
      endcase
   endfunction

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      if (a == 3'd0) m_idx = d[1:0];
      else if (a == 3'd1) begin
         case (m_idx)
            2'd0: m_c0 = d;
            2'd1: m_c1 = d;
            2'd2: m_pout = d & m_ddr;
            default: m_ddr = d;
         endcase
      end
   endtask

   task automatic rd_chk(input logic [2:0] a, input string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      chk(tag, {24'b0, bus_rdata}, {24'b0, exp_rd(a)});
      bus_sel = 1'b0;
   endtask

   task automatic outs_chk();
      chk("R2 port_oe", {24'b0, port_oe}, {24'b0, m_ddr});
      chk("R3 port_out", {24'b0, port_out}, {24'b0, m_pout});
      chk("R5 div_ratio", {30'b0, div_ratio}, {30'b0, exp_div(m_c0)});
      chk("R6 chan_en", {29'b0, chan_en}, {29'b0, m_c0[4:2]});
      chk("R6 sw/src", {30'b0, switch_on_dis, irq_src_sel}, {30'b0, m_c0[5], m_c0[6]});
      chk("R7 cont_clk_en", {28'b0, cont_clk_en}, {28'b0, m_c1[3:0]});
   endtask

   task automatic set_in(input logic ff, input logic sd);
      logic old_irq;
      old_irq = m_stat[0] | m_stat[5];
      @(negedge clk);
      frame_flag = ff; slave_data = sd;
      @(negedge clk);
      m_stat = {2'b0, sd, 4'b0, ff};
      chk("R9 irq one edge", {31'b0, irq}, {31'b0, old_irq});
      rd_chk(3'd5, "R8 status");
      chk("R9 irq two edges", {31'b0, irq}, {31'b0, m_stat[0] | m_stat[5]});
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5EED1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      @(negedge clk);
      chk("R11 irq", {31'b0, irq}, 32'd0);
      outs_chk();
      rd_chk(3'd0, "R11 index");
      rd_chk(3'd5, "R11 status");
      for (int i = 0; i < 4; i++) begin
         wr(3'd0, 8'(i));
         rd_chk(3'd1, "R11 indexed reg");
      end
      // R1 only low two bits kept
      wr(3'd0, 8'hFE);
      rd_chk(3'd0, "R1 index FE");
      chk("R1 index value", {30'b0, m_idx}, 32'd2);
      // R3 masked port write and R4 read zero
      wr(3'd0, 8'd3); wr(3'd1, 8'h0F); outs_chk();
      wr(3'd0, 8'd2); wr(3'd1, 8'hFF);
      chk("R3 masked", {24'b0, port_out}, 32'h0F);
      rd_chk(3'd1, "R4 write-only reads zero");
      wr(3'd0, 8'd3); wr(3'd1, 8'hF0);
      chk("R3 hold after ddr change", {24'b0, port_out}, 32'h0F);
      rd_chk(3'd1, "R2 ddr readback");
      // R5 divider values
      wr(3'd0, 8'd0);
      for (int v = 0; v < 4; v++) begin
         wr(3'd1, 8'(v));
         chk("R5 div", {30'b0, div_ratio}, {30'b0, exp_div(8'(v))});
      end
      // R6 enables, R7 continuous clocks
      wr(3'd1, 8'h7C); outs_chk();
      wr(3'd1, 8'h94); outs_chk();
      rd_chk(3'd1, "R2 ctrl0 readback");
      wr(3'd0, 8'd1); wr(3'd1, 8'hA5); outs_chk();
      rd_chk(3'd1, "R2 ctrl1 readback");
      // R8 R9 status and interrupt
      set_in(1'b1, 1'b0);
      set_in(1'b0, 1'b0);
      set_in(1'b0, 1'b1);
      set_in(1'b1, 1'b1);
      set_in(1'b0, 1'b0);
      // R10 port input
      port_in = 8'h3C; rd_chk(3'd6, "R10 port_in");
      port_in = 8'hC3; rd_chk(3'd6, "R10 port_in");
      // R12 other offsets ignore writes and read zero
      for (int a = 2; a < 8; a++) wr(3'(a), 8'hFF);
      outs_chk();
      rd_chk(3'd0, "R12 index unchanged");
      rd_chk(3'd5, "R12 status unchanged");
      rd_chk(3'd2, "R12 off2"); rd_chk(3'd3, "R12 off3");
      rd_chk(3'd4, "R12 off4"); rd_chk(3'd7, "R12 off7");
      // Random mix
      for (int n = 0; n < 400; n++) begin
         int op;
         op = $urandom_range(0, 5);
         case (op)
            0: wr(3'd0, 8'($urandom));
            1, 2: begin wr(3'd1, 8'($urandom)); outs_chk(); end
            3: rd_chk(3'($urandom_range(0, 7)), "R12 random read");
            4: set_in(1'($urandom), 1'($urandom));
            default: begin
               port_in = 8'($urandom);
               wr(3'($urandom_range(2, 7)), 8'($urandom));
               outs_chk();
               rd_chk(3'd6, "R10 random port_in");
            end
         endcase
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule